// File: doc/BRIEF.md
# Masked-Update Latched Status Register

This block is an eight-bit status register on a small synchronous processor bus. Each bit position is either latched or real-time, as chosen by a parameter. A latched position captures one-cycle event pulses that arrive with no relation to bus traffic. It keeps the captured one until software clears it. A real-time position shows a live condition input as it is at that moment and keeps no history.

Software does not clear bits directly. A write to the status address carries a select mask. Each selected latched bit is copied into a read image and then cleared. Unselected bits keep their earlier image value. The read that follows returns the image for latched positions and the live inputs for real-time positions.

Software can AND what it reads with the mask it wrote and write the result back. This clears once more the bits it saw set, and does not disturb any other bit. A separate interrupt mask register gates the latched bits onto an interrupt output.

Top module: `evt_status_reg`

## Requirements
- R1: While reset is asserted and after it is released, all latched bits, all image bits, the interrupt mask and the read data are zero, and `irq_o` is low.
- R2: A one on `evt_i[k]` at a latched position k sets latched bit k in that clock cycle. The bit stays set until a status write selects it. Event pulses on real-time positions have no effect.
- R3: A status write (`addr_i`=0) with `wdata_i[k]`=1 at a latched position k copies latched bit k into image bit k and clears latched bit k. A second selecting write with no event in between puts a zero into the image.
- R4: A status write with `wdata_i[k]`=0 leaves image bit k and latched bit k unchanged.
- R5: A status read returns image bit k at latched positions and `live_i[k]` at real-time positions. With the default map `LATCH_MAP`=8'h3F, bits 0 to 5 are latched and bits 6 and 7 are real-time. Writes do not alter the real-time bits.
- R6: A read strobe (`cs_i`&`rd_i`) updates `rdata_o` one clock later. Without a read strobe, `rdata_o` holds its value.
- R7: If an event and a selecting write reach the same latched bit in the same cycle, the latched bit stays set. The image receives the value the latched bit had before that cycle.
- R8: A write to address 1 loads the interrupt mask. A read of address 1 returns the mask.
- R9: `irq_o` is high exactly when some latched bit and its interrupt mask bit are both one.
- R10: An event that lands between a snapshot write and the following read-back write stays latched. A write-back of (read AND mask) clears only the bits that were selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Chip select, one-cycle strobe qualifier |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | 0 = status register, 1 = interrupt mask |
| wdata_i | input | 8 | Write data / select mask |
| rdata_o | output | 8 | Registered read data |
| evt_i | input | 8 | One-cycle event pulses, one per bit position |
| live_i | input | 8 | Real-time condition levels |
| irq_o | output | 1 | Interrupt, level |

## Verification
The assertions assume three things about the inputs. A bus strobe lasts one cycle. Write and read are never given in the same cycle. The event inputs are sampled synchronously, so a pulse counts in exactly the cycle where it is high. The bench drives every strobe and pulse for exactly one clock, changing inputs only on the falling edge, and never combines read and write. The sweep runs all 64 event patterns on the latched bits, each against a different select mask and interrupt mask, and keeps a bench-side model of the latched and image state built from the requirements.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int unsigned DW = 8;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_IMASK  = 1'b1;
  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/esr_rst_sync.sv
module esr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/esr_latch_cell.sv
module esr_latch_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic sel_i,
  output logic lat_o,
  output logic img_o
);
  logic lat_q, lat_d;
  logic img_q, img_d;
  logic img_en;

  always_comb begin
    lat_d  = evt_i | (lat_q & ~sel_i);
    img_en = sel_i;
    img_d  = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      img_q <= 1'b0;
    else if (img_en) img_q <= img_d;
  end

  assign lat_o = lat_q;
  assign img_o = img_q;

  // R2
  lat_set_on_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> lat_q);
  // R3
  lat_clear_on_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !evt_i) |=> !lat_q);
  // R3
  img_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |=> (img_q == $past(lat_q)));
  // R4
  img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(img_q));
endmodule

// File: rtl/esr_rdport.sv
module esr_rdport
  import esr_pkg::*;
#(
  parameter word_t LATCH_MAP = 8'h3F
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_stb_i,
  input  logic  addr_i,
  input  word_t img_i,
  input  word_t live_i,
  input  word_t imask_i,
  output word_t rdata_o
);
  word_t rdata_q, rdata_d, status_w;

  always_comb begin
    status_w = (img_i & LATCH_MAP) | (live_i & ~LATCH_MAP);
    rdata_d  = (addr_i == ADDR_IMASK) ? imask_i : status_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rd_stb_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rdata_q));
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import esr_pkg::*;
#(
  parameter word_t LATCH_MAP = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] evt_i,
  input  logic [7:0] live_i,
  output logic       irq_o
);
  logic  rst_sync_n;
  logic  wr_status, wr_imask, rd_stb;
  word_t lat_w, img_w;
  word_t imask_q, imask_d;

  esr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_status = cs_i & wr_i & (addr_i == ADDR_STATUS);
    wr_imask  = cs_i & wr_i & (addr_i == ADDR_IMASK);
    rd_stb    = cs_i & rd_i;
    imask_d   = wdata_i;
  end

  for (genvar k = 0; k < DW; k++) begin : g_bit
    if (LATCH_MAP[k]) begin : g_latched
      esr_latch_cell u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .evt_i (evt_i[k]),
        .sel_i (wr_status & wdata_i[k]),
        .lat_o (lat_w[k]),
        .img_o (img_w[k])
      );
    end else begin : g_live
      assign lat_w[k] = 1'b0;
      assign img_w[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   imask_q <= '0;
    else if (wr_imask) imask_q <= imask_d;
  end

  assign irq_o = |(lat_w & imask_q);

  esr_rdport #(.LATCH_MAP(LATCH_MAP)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_stb_i (rd_stb),
    .addr_i   (addr_i),
    .img_i    (img_w),
    .live_i   (live_i),
    .imask_i  (imask_q),
    .rdata_o  (rdata_o)
  );

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> ($past(|(evt_i & LATCH_MAP)) || $past(wr_imask)));
  // R9
  irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_o) |-> ($past(wr_status) || $past(wr_imask)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq_o && rdata_o == 8'h00));
endmodule

// File: tb/sim_evt_status_reg.sv
module sim_evt_status_reg;
  localparam logic [7:0] LM = 8'h3F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = '0, evt_i = '0, live_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int tests = 0, fails = 0;
  logic [7:0] m_lat = '0, m_img = '0, m_imask = '0;
  logic [7:0] got;

  always #2 clk = ~clk;

  evt_status_reg #(.LATCH_MAP(LM)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .live_i(live_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
    m_lat = m_lat | (v & LM);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] ev);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0; wdata_i = '0; evt_i = '0;
    if (a == 1'b0) begin
      m_img = (m_img & ~d) | (m_lat & d);
      m_lat = (m_lat & ~d) | (ev & LM);
    end else begin
      m_imask = d;
      m_lat = m_lat | (ev & LM);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    cs_i = 1'b0; rd_i = 1'b0;
    v = rdata_o;
  endtask

  function automatic logic [7:0] st_exp();
    return (m_img & LM) | (live_i & ~LM);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 rdata in reset", rdata_o, 8'h00);
    chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(1'b0, got); chk("R1 status after reset", got, 8'h00);
    rd(1'b1, got); chk("R1 imask after reset", got, 8'h00);

    // R2, R3, R4, R5, R8, R9: sweep all latched event patterns
    for (int p = 0; p < 64; p++) begin
      logic [7:0] sm, im;
      sm = 8'(p) ^ 8'h15 ^ 8'(p << 3);
      im = 8'(p * 5 + 1);
      live_i = 8'(p << 2);
      wr(1'b0, 8'hFF, 8'h00);
      wr(1'b0, 8'hFF, 8'h00);
      pulse(8'(p) | 8'hC0);
      wr(1'b1, im, 8'h00);
      rd(1'b1, got); chk("R8 imask readback", got, m_imask);
      chk("R9 irq level", {7'd0, irq_o}, {7'd0, |(m_lat & m_imask)});
      wr(1'b0, sm, 8'h00);
      rd(1'b0, got); chk("R3/R4/R5 snapshot read", got, st_exp());
      chk("R9 irq after clear", {7'd0, irq_o}, {7'd0, |(m_lat & m_imask)});
      wr(1'b0, 8'hFF, 8'h00);
      rd(1'b0, got); chk("R2/R3 residue after full select", got, st_exp());
      chk("R2 residue matches unselected events", got & LM, 8'(p) & ~sm & LM);
    end

    // R3: double select with no event returns zero
    wr(1'b0, 8'hFF, 8'h00);
    rd(1'b0, got); chk("R3 second select zero", got & LM, 8'h00);

    // R6: rdata holds without a read strobe
    pulse(8'h21);
    rd(1'b0, got);
    wr(1'b0, 8'h21, 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 rdata held", rdata_o, got);
    rd(1'b0, got); chk("R6 rdata updated next cycle", got, st_exp());

    // R5: live bits follow input; event on real-time bit ignored
    live_i = 8'h80;
    pulse(8'h40);
    rd(1'b0, got); chk("R5 live bits", got & ~LM, 8'h80);
    live_i = 8'h40;
    rd(1'b0, got); chk("R5 live bits change", got & ~LM, 8'h40);

    // R7: event and clear in the same cycle
    wr(1'b0, 8'hFF, 8'h00);
    wr(1'b0, 8'hFF, 8'h00);
    pulse(8'h04);
    wr(1'b0, 8'h04, 8'h04);
    rd(1'b0, got); chk("R7 image has old value", got & LM, 8'h04);
    wr(1'b0, 8'h04, 8'h00);
    rd(1'b0, got); chk("R7 event kept latched", got & LM, 8'h04);

    // R10: write-read-write sequence with event landing between
    wr(1'b0, 8'hFF, 8'h00);
    wr(1'b0, 8'hFF, 8'h00);
    pulse(8'h03);
    wr(1'b0, 8'h03, 8'h00);
    pulse(8'h01);
    pulse(8'h10);
    rd(1'b0, got); chk("R10 first read", got & LM, 8'h03);
    wr(1'b0, got & 8'h03, 8'h00);
    rd(1'b0, got); chk("R10 late event preserved", got & LM, 8'h01);
    wr(1'b0, 8'h10, 8'h00);
    rd(1'b0, got); chk("R10 unselected bit kept", got & LM, 8'h11);

    // R9: mask zero blocks irq
    pulse(8'h3F);
    wr(1'b1, 8'h00, 8'h00);
    chk("R9 irq masked", {7'd0, irq_o}, 8'h00);
    wr(1'b1, 8'h20, 8'h00);
    chk("R9 irq unmasked", {7'd0, irq_o}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule